// File: doc/BRIEF.md
# Unaligned Byte-Stream Memory Writer

This block copies a run of bytes from a host stream into a memory built from 32-bit words. The run can start at any byte address and have any length. A request gives a byte pointer and a byte count. The block then takes bytes from a valid/ready stream and writes them to memory in up to three phases. The first phase writes single bytes until the pointer reaches a word boundary. The second writes whole words in groups. The third writes any trailing bytes one at a time.

A single-byte write is a read-modify-write of the enclosing word. The block reads the word, replaces one byte lane and writes the word back.

A group step always issues four word writes, one per cycle. Slots that carry stream data come first. Any slot without data writes zero to a fixed dummy word, so every group step has the same shape.

When the run ends, a one-cycle done pulse reports the number of bytes written.

Top module: `stream_mem_writer`

## Requirements
- R1: A request with length 0 produces a done pulse on the cycle after start, with done_count 0. It takes no stream bytes and makes no memory read or write.
- R2: While the byte offset (pointer bits 1:0) is nonzero and bytes remain, each step consumes exactly one stream byte and makes one read followed by one write of the same word. The pointer then advances by one byte and the count drops by one.
- R3: A single-byte step changes only the byte lane selected by the offset. Offset value n selects bits 8n+7..8n. The other three bytes keep the value that was read.
- R4: When the pointer is word aligned and at least 4 bytes remain, a group step writes min(4, remaining/4) consecutive whole words, starting at the current word address.
- R5: Every group step issues exactly four writes. Each slot that carries no data writes the value 0 to the word address set by the parameter DUMMY_WADDR.
- R6: In a group step, word data is little-endian: the k-th stream byte of the word goes to bits 8k+7..8k.
- R7: After a group step, the block finishes if no bytes remain. It starts another group step if 4 or more bytes remain. Otherwise it writes the last 1 to 3 bytes one per step, as in R2 and R3.
- R8: On completion, done is high for exactly one cycle, and done_count equals the requested length.
- R9: A start pulse while busy is high is ignored. The running transfer finishes unchanged, with a single done pulse.
- R10: After reset, and whenever busy is low, in_ready, mem_rd_en, mem_wr_en and done are all low.
- R11: No memory word is written other than the words that hold the target bytes and the dummy word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a request; accepted only while busy is low |
| start_ptr | input | AW+2 | Byte pointer of the first destination byte |
| start_len | input | LW | Number of bytes to copy |
| busy | output | 1 | High from an accepted start through the done cycle |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is present |
| in_ready | output | 1 | Block takes the byte this cycle when in_valid is high |
| mem_rd_en | output | 1 | Word read request (data returned one cycle later) |
| mem_rd_addr | output | AW | Word address to read |
| mem_rd_data | input | 32 | Read data, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Word write strobe |
| mem_wr_addr | output | AW | Word address to write |
| mem_wr_data | output | 32 | Word data to write |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LW | Bytes written, valid while done is high |

## Verification
Two things can land on the same cycle. The fourth byte of a word arrives on the stream, and the block must issue that word's write in the same cycle, with the incoming byte placed straight into the top lane. A second case is a late start pulse that reaches a transfer already in progress.

The bench stalls the stream on a fixed cycle pattern, so the fourth byte arrives sometimes right after a stall and sometimes back to back. Every written byte is then checked against its stream index, and every byte outside the buffer is checked against its background value.

A start pulse is also injected in the middle of a transfer. The memory image, the done count and the number of done pulses show whether it was ignored.

// File: rtl/smw_pkg.sv
package smw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYTE_RD,
        ST_BYTE_WR,
        ST_GROUP,
        ST_FIN
    } smw_state_e;

    // Phase chosen from the current byte offset and remaining count
    function automatic smw_state_e pick_phase(input logic [1:0] ofs, input logic [31:0] left);
        if (left == 32'd0)
            return ST_FIN;
        else if (ofs == 2'd0 && left >= 32'd4)
            return ST_GROUP;
        else
            return ST_BYTE_RD;
    endfunction

    // Whole words carried by one group step: min(4, left/4)
    function automatic logic [2:0] group_words(input logic [31:0] left);
        if (left >= 32'd16)
            return 3'd4;
        else
            return left[4:2];
    endfunction

endpackage

// File: rtl/smw_lane_merge.sv
module smw_lane_merge (
    input  logic [31:0] old_word,
    input  logic [1:0]  lane,
    input  logic [7:0]  new_byte,
    output logic [31:0] merged
);
    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign merged[8*i +: 8] = (lane == 2'(i)) ? new_byte : old_word[8*i +: 8];
    end
endmodule

// File: rtl/smw_word_packer.sv
module smw_word_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [1:0]  idx,
    input  logic [7:0]  din,
    output logic [31:0] word
);
    logic [7:0] held [3];

    for (genvar i = 0; i < 3; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                held[i] <= 8'd0;
            else if (load && idx == 2'(i))
                held[i] <= din;
        end
        assign word[8*i +: 8] = held[i];
    end
    // Top lane comes straight from the stream so the word completes in one cycle
    assign word[31:24] = din;
endmodule

// File: rtl/stream_mem_writer.sv
module stream_mem_writer #(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter logic [AW-1:0] DUMMY_WADDR = {AW{1'b1}}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW+1:0] start_ptr,
    input  logic [LW-1:0] start_len,
    output logic          busy,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    output logic          done,
    output logic [LW-1:0] done_count
);
    import smw_pkg::*;

    smw_state_e    state;
    logic [AW-1:0] wptr;
    logic [1:0]    ofs;
    logic [LW-1:0] left;
    logic [LW-1:0] total;
    logic [2:0]    nwords;
    logic [1:0]    slot;
    logic [1:0]    bidx;
    logic [7:0]    byte_q;

    logic          slot_used;
    logic          take;
    logic          grp_wr;
    logic [31:0]   packed_word;
    logic [31:0]   merged_word;
    logic [LW-1:0] left_after_byte;
    logic [LW-1:0] left_after_grp;
    logic [1:0]    ofs_next;
    logic          wrap;

    assign slot_used = ({1'b0, slot} < nwords);
    assign in_ready  = (state == ST_BYTE_RD) || (state == ST_GROUP && slot_used);
    assign take      = in_ready && in_valid;
    assign grp_wr    = (state == ST_GROUP) && (slot_used ? (in_valid && bidx == 2'd3) : 1'b1);

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FIN);
    assign done_count = total;

    assign mem_rd_en   = (state == ST_BYTE_RD) && in_valid;
    assign mem_rd_addr = wptr;

    smw_word_packer u_pack (
        .clk  (clk),
        .rst  (rst),
        .load (take && state == ST_GROUP),
        .idx  (bidx),
        .din  (in_data),
        .word (packed_word)
    );

    smw_lane_merge u_merge (
        .old_word (mem_rd_data),
        .lane     (ofs),
        .new_byte (byte_q),
        .merged   (merged_word)
    );

    always_comb begin
        mem_wr_en   = 1'b0;
        mem_wr_addr = wptr;
        mem_wr_data = merged_word;
        if (state == ST_BYTE_WR) begin
            mem_wr_en = 1'b1;
        end else if (grp_wr) begin
            mem_wr_en   = 1'b1;
            mem_wr_addr = slot_used ? (wptr + AW'(slot)) : DUMMY_WADDR;
            mem_wr_data = slot_used ? packed_word : 32'd0;
        end
    end

    assign left_after_byte = left - LW'(1);
    assign left_after_grp  = left - LW'({nwords, 2'b00});
    assign ofs_next        = ofs + 2'd1;
    assign wrap            = (ofs == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wptr   <= '0;
            ofs    <= '0;
            left   <= '0;
            total  <= '0;
            nwords <= '0;
            slot   <= '0;
            bidx   <= '0;
            byte_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        wptr   <= start_ptr[AW+1:2];
                        ofs    <= start_ptr[1:0];
                        left   <= start_len;
                        total  <= start_len;
                        nwords <= group_words(32'(start_len));
                        slot   <= '0;
                        bidx   <= '0;
                        state  <= pick_phase(start_ptr[1:0], 32'(start_len));
                    end
                end
                ST_BYTE_RD: begin
                    if (in_valid) begin
                        byte_q <= in_data;
                        state  <= ST_BYTE_WR;
                    end
                end
                ST_BYTE_WR: begin
                    ofs    <= ofs_next;
                    wptr   <= wrap ? wptr + AW'(1) : wptr;
                    left   <= left_after_byte;
                    nwords <= group_words(32'(left_after_byte));
                    slot   <= '0;
                    bidx   <= '0;
                    state  <= pick_phase(ofs_next, 32'(left_after_byte));
                end
                ST_GROUP: begin
                    if (take)
                        bidx <= bidx + 2'd1;
                    if (grp_wr) begin
                        slot <= slot + 2'd1;
                        if (slot == 2'd3) begin
                            wptr   <= wptr + AW'(nwords);
                            left   <= left_after_grp;
                            nwords <= group_words(32'(left_after_grp));
                            state  <= pick_phase(2'd0, 32'(left_after_grp));
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stream_mem_writer_chk.sv
module stream_mem_writer_chk #(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter logic [AW-1:0] DUMMY_WADDR = {AW{1'b1}}
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW+1:0] start_ptr,
    input logic [LW-1:0] start_len,
    input logic          busy,
    input logic [7:0]    in_data,
    input logic          in_valid,
    input logic          in_ready,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic [31:0]   mem_rd_data,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr,
    input logic [31:0]   mem_wr_data,
    input logic          done,
    input logic [LW-1:0] done_count
);
    logic [LW-1:0] req_len;

    always_ff @(posedge clk) begin
        if (rst)
            req_len <= '0;
        else if (start && !busy)
            req_len <= start_len;
    end

    // R1
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && start_len == '0) |=> (done && done_count == '0));

    // R2
    rmw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (mem_wr_en && mem_wr_addr == $past(mem_rd_addr)));

    // R5
    dummy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr == DUMMY_WADDR) |-> (mem_wr_data == 32'd0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_count == req_len));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr_en && !mem_rd_en && !in_ready && !done));
endmodule

bind stream_mem_writer stream_mem_writer_chk #(
    .AW(AW), .LW(LW), .DUMMY_WADDR(DUMMY_WADDR)
) u_chk (.*);

// File: tb/stream_mem_writer_bench.sv
module stream_mem_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int LW = 16;
    localparam logic [AW-1:0] DUMMY = 8'hFF;
    localparam int BASE = 64;
    localparam int NLEN = 11;
    localparam int LEN_TAB [NLEN] = '{0, 1, 2, 3, 4, 5, 7, 13, 19, 40, 101};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW+1:0] start_ptr = '0;
    logic [LW-1:0] start_len = '0;
    logic          busy;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic          done;
    logic [LW-1:0] done_count;

    int errs = 0;
    int checks = 0;

    logic [31:0] mem [256];
    logic [31:0] rd_q = '0;
    int sent = 0;
    int nwr = 0;
    int ndummy = 0;
    int ndone = 0;
    int last_count = 0;
    int cyc = 0;

    assign mem_rd_data = rd_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_mem_writer #(.AW(AW), .LW(LW), .DUMMY_WADDR(DUMMY)) u_stream_mem_writer (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr), .start_len(start_len),
        .busy(busy), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .done_count(done_count)
    );

    // Memory model and monitor
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_rd_en) rd_q <= mem[mem_rd_addr];
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            nwr = nwr + 1;
            if (mem_wr_addr == DUMMY) ndummy = ndummy + 1;
        end
        if (in_valid && in_ready) sent = sent + 1;
        if (done) begin
            ndone = ndone + 1;
            last_count = int'(done_count);
        end
    end

    function automatic logic [7:0] bg(input int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_bg();
        for (int w = 0; w < 256; w++)
            for (int b = 0; b < 4; b++)
                mem[w][8*b +: 8] = bg(w * 4 + b);
    endtask

    // Runs one request; inject > 0 pulses a bogus start at that cycle of the transfer
    task automatic run_xfer(input int ofs, input int len, input int inject);
        int t;
        int lead, rem, words, steps, trail, exp_wr, exp_dummy;
        int bad, bad_at, bad_val, bad_exp;
        logic [7:0] want;
        fill_bg();
        sent = 0; nwr = 0; ndummy = 0; ndone = 0; last_count = -1;
        @(negedge clk);
        start = 1'b1;
        start_ptr = (AW+2)'(BASE + ofs);
        start_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (ndone == 0 && t < 3000) begin
            in_valid = (sent < len) && ((cyc % 5) != 2);
            in_data = 8'(sent);
            if (inject > 0 && t == inject) begin
                start = 1'b1;
                start_ptr = (AW+2)'(8);
                start_len = LW'(5);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(t < 3000, "R8", "transfer finished", t, 0);

        // expected write counts
        lead = (ofs == 0) ? 0 : ((len < 4 - ofs) ? len : 4 - ofs);
        rem = len - lead;
        words = rem / 4;
        steps = (words + 3) / 4;
        trail = rem % 4;
        exp_wr = lead * 1 + steps * 4 + trail;
        exp_dummy = steps * 4 - words;
        if (ofs == 0 && len < 4) begin
            exp_wr = len; exp_dummy = 0;
        end
        check(nwr == exp_wr, (len == 0) ? "R1" : "R2 R4 R7", "write count", nwr, exp_wr);
        check(ndummy == exp_dummy, "R5", "dummy writes", ndummy, exp_dummy);
        check(ndone == 1 && last_count == len, "R8 R9", "done pulses/count",
              ndone * 1000 + last_count, 1000 + len);

        bad = 0; bad_at = 0; bad_val = 0; bad_exp = 0;
        for (int w = 0; w < 255; w++) begin
            for (int b = 0; b < 4; b++) begin
                int a;
                a = w * 4 + b;
                if (a >= BASE + ofs && a < BASE + ofs + len) want = 8'(a - BASE - ofs);
                else want = bg(a);
                if (mem[w][8*b +: 8] !== want && bad == 0) begin
                    bad = 1; bad_at = a; bad_val = int'(mem[w][8*b +: 8]); bad_exp = int'(want);
                end
            end
        end
        if (bad != 0)
            $display("FAIL R3 R6 R11 mismatch at byte %0d (ofs %0d len %0d)", bad_at, ofs, len);
        check(bad == 0, "R3 R6 R7 R11", "memory image byte", bad_val, bad_exp);
    endtask

    initial begin
        fill_bg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!busy && !done && !in_ready && !mem_wr_en && !mem_rd_en, "R10", "idle outputs",
              int'({busy, done, in_ready, mem_wr_en, mem_rd_en}), 0);

        for (int o = 0; o < 4; o++)
            for (int i = 0; i < NLEN; i++)
                run_xfer(o, LEN_TAB[i], 0);

        // R9: start pulse in the middle of a transfer
        run_xfer(1, 40, 12);
        run_xfer(0, 101, 30);

        // R1 + R10: zero length leaves block idle afterwards
        run_xfer(3, 0, 0);
        check(!busy && !in_ready, "R1 R10", "idle after empty request", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule